// File: doc/BRIEF.md
# Dual-Half Monochrome LCD Scan Data Fetcher

This block keeps a one-bit-per-pixel image of a 640 by 480 monochrome panel in on-chip RAM. It feeds the panel's 8-bit data bus while a separate timing generator paces the scan. The panel is scanned as two independent halves. On every transfer the block drives a 4-pixel nibble for the top half and a 4-pixel nibble for the bottom half at the same time. Each line takes 160 transfers. Each frame takes 242 line periods, and only the first 240 of them are visible.

The timing generator sends three single-cycle strobes: frame restart, line start and transfer. The block keeps a line counter and a column counter from these strobes. It reads the top-half row and the matching bottom-half row, 240 rows further down the image, from two RAM banks. It fetches the next nibble pair one transfer ahead, so the RAM read latency is hidden. The presented nibbles are held steady between transfers, so they are stable around the panel's falling shift-clock edge. A CPU-side write port updates the image one byte at a time.

Top module: `lcd_scan_fetch`

## Requirements
- R1: While `rst_n` is low, and after reset until the first transfer, both nibble outputs are 0 and the line and column counters are 0.
- R2: A `frame_start` strobe sets the line counter and the column counter to 0. It takes priority over `line_start` and `xfer` in the same cycle.
- R3: A transfer taken on line L (L below 240) at column c makes `upper_nib` equal to pixels 4c to 4c+3 of image row L, and `lower_nib` equal to the same pixels of row L+240. Image byte b of a row holds pixels 8b to 8b+7, with the leftmost pixel in bit 7. Within a nibble, the leftmost pixel is in bit 3. The data is correct when each transfer comes at least two cycles after the previous transfer or line strobe.
- R4: Each taken transfer advances the column by one. A `line_start` strobe without `frame_start` resets the column to 0 and advances the line by one, stopping at 241. A transfer in the same cycle as either strobe is ignored.
- R5: On lines 240 and 241 every transfer drives both nibbles to 0.
- R6: The nibble outputs change only on a clock edge where a transfer is taken.
- R7: Transfers past the 160th on one line drive both nibbles to 0, and the column stops at 160.
- R8: A write with `wr_en` high stores `wr_data` into image row `wr_row` (0 to 479), byte `wr_byte` (0 to 79). A write with a row of 480 or more, or a byte of 80 or more, changes no stored pixel.
- R9: A write to the word the prefetch is reading in the same cycle leaves the old value for a transfer in the next cycle. A transfer two or more cycles after the write shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame restart strobe, one cycle |
| line_start | input | 1 | Line start strobe, one cycle |
| xfer | input | 1 | Transfer strobe: present the next nibble pair |
| wr_en | input | 1 | CPU write enable |
| wr_row | input | 9 | CPU write image row |
| wr_byte | input | 7 | CPU write byte index within the row |
| wr_data | input | 8 | CPU write data, bit 7 is the leftmost pixel |
| upper_nib | output | 4 | Top-half pixel nibble, bit 3 is the leftmost pixel |
| lower_nib | output | 4 | Bottom-half pixel nibble, bit 3 is the leftmost pixel |

## Verification
Two situations are hard to reach from the ports. The first is the collision between a CPU write and the prefetch read of the same word, which shows up only if the next transfer lands exactly one cycle after the write. The stimulus parks the column on a known word, writes it, and fires the transfer at once. It then repeats the case with one idle cycle in between to see the new value. The second is the pair of blank line periods at the end of a frame, which only appear after 240 full lines. The bench drives a complete frame of 242 lines with randomly placed idle gaps and checks every one of the 160 transfers per line against a pattern function.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  // Bit index of the least significant bit of nibble `col` within a row word.
  // Byte b sits at bits [8b+7:8b]; the even nibble is its high half.
  function automatic int nib_lsb(input int col);
    return (col / 2) * BYTE_W + (((col % 2) == 0) ? NIB_W : 0);
  endfunction
endpackage

// File: rtl/lcdf_bank.sv
module lcdf_bank #(
  parameter int ROW_BITS = 640,
  parameter int DEPTH    = 240,
  parameter int COLS     = 160,
  parameter int AW       = 8,
  parameter int BW       = 7,
  parameter int CW       = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_row,
  input  logic [BW-1:0] wr_byte,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic [3:0]    rd_nib
);
  import lcdf_pkg::*;
  localparam int BYTES = ROW_BITS / BYTE_W;

  logic [ROW_BITS-1:0] mem [DEPTH];

  logic wr_ok, rd_ok;
  assign wr_ok = wr_en && (int'(wr_row) < DEPTH) && (int'(wr_byte) < BYTES);
  assign rd_ok = (int'(rd_row) < DEPTH) && (int'(rd_col) < COLS);

  // Read and write share the edge: a read of the word being written sees the old data.
  always_ff @(posedge clk) begin
    if (wr_ok)
      mem[wr_row][int'(wr_byte) * BYTE_W +: BYTE_W] <= wr_data;
    if (rd_ok)
      rd_nib <= mem[rd_row][nib_lsb(int'(rd_col)) +: NIB_W];
    else
      rd_nib <= '0;
  end
endmodule

// File: rtl/lcdf_scan_ctr.sv
module lcdf_scan_ctr #(
  parameter int COLS   = 160,
  parameter int HALF   = 240,
  parameter int LINES  = 242,
  parameter int CW     = 8,
  parameter int LW     = 8,
  parameter int AW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic          xfer_go,
  output logic [LW-1:0] line_q,
  output logic [CW-1:0] col_q,
  output logic [AW-1:0] row_q,
  output logic          blank
);
  logic line_adv, row_adv, col_adv;
  assign line_adv = int'(line_q) < LINES - 1;
  assign row_adv  = int'(line_q) + 1 < HALF;
  assign col_adv  = int'(col_q) < COLS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      col_q  <= '0;
      row_q  <= '0;
    end else if (frame_start) begin
      line_q <= '0;
      col_q  <= '0;
      row_q  <= '0;
    end else if (line_start) begin
      col_q <= '0;
      if (line_adv) line_q <= line_q + 1'b1;
      // Read row holds during the non-displayed line periods.
      if (row_adv)  row_q  <= row_q + 1'b1;
    end else if (xfer_go && col_adv) begin
      col_q <= col_q + 1'b1;
    end
  end

  assign blank = int'(line_q) >= HALF;
endmodule

// File: rtl/lcd_scan_fetch.sv
module lcd_scan_fetch #(
  parameter  int H_PIX       = 640,
  parameter  int V_PIX       = 480,
  parameter  int EXTRA_LINES = 2,
  localparam int ROW_AW      = $clog2(V_PIX),
  localparam int BYTE_AW     = $clog2(H_PIX / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               line_start,
  input  logic               xfer,
  input  logic               wr_en,
  input  logic [ROW_AW-1:0]  wr_row,
  input  logic [BYTE_AW-1:0] wr_byte,
  input  logic [7:0]         wr_data,
  output logic [3:0]         upper_nib,
  output logic [3:0]         lower_nib
);
  localparam int COLS   = H_PIX / 4;
  localparam int HALF   = V_PIX / 2;
  localparam int LINES  = HALF + EXTRA_LINES;
  localparam int COL_W  = $clog2(COLS + 1);
  localparam int LINE_W = $clog2(LINES);
  localparam int HROW_W = $clog2(HALF);

  // Named internal events, also observed by the bound checker.
  logic              xfer_go;
  logic              blank;
  logic [LINE_W-1:0] line_q;
  logic [COL_W-1:0]  col_q;
  logic [HROW_W-1:0] row_q;

  assign xfer_go = xfer && !line_start && !frame_start;

  lcdf_scan_ctr #(
    .COLS(COLS), .HALF(HALF), .LINES(LINES),
    .CW(COL_W), .LW(LINE_W), .AW(HROW_W)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .line_start(line_start), .xfer_go(xfer_go),
    .line_q(line_q), .col_q(col_q), .row_q(row_q), .blank(blank)
  );

  // Write decode: rows below HALF go to bank 0 (top), the rest to bank 1 (bottom).
  logic [ROW_AW-1:0] lo_row_full;
  logic              bank_en  [2];
  logic [HROW_W-1:0] bank_row [2];
  logic [3:0]        bank_nib [2];

  assign lo_row_full = wr_row - ROW_AW'(HALF);

  always_comb begin
    bank_en[0]  = wr_en && (int'(wr_row) < HALF);
    bank_en[1]  = wr_en && (int'(wr_row) >= HALF) && (int'(wr_row) < V_PIX);
    bank_row[0] = HROW_W'(wr_row);
    bank_row[1] = HROW_W'(lo_row_full);
  end

  for (genvar h = 0; h < 2; h++) begin : g_bank
    lcdf_bank #(
      .ROW_BITS(H_PIX), .DEPTH(HALF), .COLS(COLS),
      .AW(HROW_W), .BW(BYTE_AW), .CW(COL_W)
    ) u_bank (
      .clk(clk), .wr_en(bank_en[h]), .wr_row(bank_row[h]),
      .wr_byte(wr_byte), .wr_data(wr_data),
      .rd_row(row_q), .rd_col(col_q), .rd_nib(bank_nib[h])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_nib <= '0;
      lower_nib <= '0;
    end else if (xfer_go) begin
      upper_nib <= blank ? 4'h0 : bank_nib[0];
      lower_nib <= blank ? 4'h0 : bank_nib[1];
    end
  end
endmodule

// File: rtl/lcdf_chk.sv
module lcdf_chk #(
  parameter int LINES  = 242,
  parameter int COLS   = 160,
  parameter int LINE_W = 8,
  parameter int COL_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_start,
  input logic              xfer_go,
  input logic              blank,
  input logic [LINE_W-1:0] line_q,
  input logic [COL_W-1:0]  col_q,
  input logic [3:0]        upper_nib,
  input logic [3:0]        lower_nib
);
  // R2
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (line_q == '0) && (col_q == '0));

  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && (int'(line_q) < LINES - 1))
      |=> (line_q == $past(line_q) + LINE_W'(1)) && (col_q == '0));

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && (int'(col_q) < COLS)) |=> (col_q == $past(col_q) + COL_W'(1)));

  // R5
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && blank) |=> (upper_nib == 4'h0) && (lower_nib == 4'h0));

  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_go |=> $stable(upper_nib) && $stable(lower_nib));

  // R7
  col_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col_q) <= COLS);

  // R7
  overrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && (int'(col_q) == COLS)) |=> (upper_nib == 4'h0) && (lower_nib == 4'h0));
endmodule

bind lcd_scan_fetch lcdf_chk #(
  .LINES(LINES), .COLS(COLS), .LINE_W(LINE_W), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
  .xfer_go(xfer_go), .blank(blank), .line_q(line_q), .col_q(col_q),
  .upper_nib(upper_nib), .lower_nib(lower_nib)
);

// File: tb/sim_lcd_scan_fetch.sv
module sim_lcd_scan_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int COLS  = 160;
  localparam int HALF  = 240;
  localparam int LINES = 242;
  localparam int BYTES = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, frame_start = 1'b0, line_start = 1'b0, xfer = 1'b0, wr_en = 1'b0;
  logic [8:0] wr_row = '0;
  logic [6:0] wr_byte = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] upper_nib, lower_nib;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int unsigned mix;
  logic [7:0] ov0 = '0, ov240 = '0;
  bit use_ov0 = 1'b0, use_ov240 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_fetch u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .xfer(xfer), .wr_en(wr_en), .wr_row(wr_row), .wr_byte(wr_byte),
    .wr_data(wr_data), .upper_nib(upper_nib), .lower_nib(lower_nib)
  );

  // Image content the bench expects: a mixing pattern plus two patched bytes.
  function automatic logic [7:0] img_byte(int r, int b);
    if (r == 0 && b == 0 && use_ov0)     return ov0;
    if (r == 240 && b == 0 && use_ov240) return ov240;
    return 8'((r * 73) ^ (b * 29) ^ (r >> 2) ^ int'(mix));
  endfunction

  // Pixels 4c..4c+3 of row r; left pixel of byte is bit 7, of nibble bit 3.
  function automatic logic [3:0] want(int r, int c);
    logic [7:0] v;
    v = img_byte(r, c / 2);
    return (c % 2 == 0) ? v[7:4] : v[3:0];
  endfunction

  task automatic check(string tag, logic [3:0] eu, logic [3:0] el);
    checks++;
    if (upper_nib !== eu || lower_nib !== el) begin
      errors++;
      $display("FAIL %s: upper=%h lower=%h expected upper=%h lower=%h",
               tag, upper_nib, lower_nib, eu, el);
    end
  endtask

  task automatic put(int r, int b, logic [7:0] d);
    wr_en = 1'b1; wr_row = 9'(r); wr_byte = 7'(b); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_line(bit f);
    line_start = 1'b1; frame_start = f;
    @(negedge clk);
    line_start = 1'b0; frame_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_xfer();
    xfer = 1'b1;
    @(negedge clk);
    xfer = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mix = $urandom(32'd2718);
    mix = $urandom;
    repeat (3) @(negedge clk);
    check("R1 in reset", 4'h0, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 4'h0, 4'h0);

    // Load the whole image through the CPU port (R8).
    for (int r = 0; r < 2 * HALF; r++)
      for (int b = 0; b < BYTES; b++) begin
        wr_en = 1'b1; wr_row = 9'(r); wr_byte = 7'(b); wr_data = img_byte(r, b);
        @(negedge clk);
      end
    wr_en = 1'b0;
    @(negedge clk);

    // One full frame with random idle gaps (R3 R4 R5 R6 R7).
    for (int ln = 0; ln < LINES; ln++) begin
      start_line(ln == 0);
      for (int c = 0; c < COLS; c++) begin
        if ($urandom % 8 == 0) @(negedge clk);
        do_xfer();
        if (ln < HALF) check("R3 R4 scan", want(ln, c), want(ln + HALF, c));
        else           check("R5 blank line", 4'h0, 4'h0);
        if (ln == 5 && c == 10) begin
          repeat (3) @(negedge clk);
          check("R6 hold", want(5, 10), want(5 + HALF, 10));
        end
      end
      if (ln == 3) begin
        do_xfer();
        check("R7 overrun", 4'h0, 4'h0);
        do_xfer();
        check("R7 overrun again", 4'h0, 4'h0);
      end
    end

    // Mid-frame restart (R2).
    start_line(1'b1);
    start_line(1'b0);
    do_xfer();
    start_line(1'b1);
    do_xfer();
    check("R2 restart", want(0, 0), want(HALF, 0));

    // Out-of-range writes are dropped (R8).
    ov0 = 8'h5A; use_ov0 = 1'b1; put(0, 0, 8'h5A);
    ov240 = 8'h3C; use_ov240 = 1'b1; put(240, 0, 8'h3C);
    put(480, 0, 8'hFF);
    put(0, 80, 8'hFF);
    put(511, 1, 8'hFF);
    start_line(1'b1);
    do_xfer();
    check("R8 range col0", want(0, 0), want(HALF, 0));
    do_xfer();
    check("R8 range col1", want(0, 1), want(HALF, 1));
    do_xfer();
    check("R8 range col2", want(0, 2), want(HALF, 2));

    // Write colliding with the prefetch read (R9).
    start_line(1'b1);
    wr_en = 1'b1; wr_row = 9'd0; wr_byte = 7'd0; wr_data = 8'hC3;
    @(negedge clk);
    wr_en = 1'b0;
    do_xfer();
    check("R9 old value", 4'h5, 4'h3);
    ov0 = 8'hC3;
    start_line(1'b1);
    do_xfer();
    check("R9 new value", 4'hC, 4'h3);
    do_xfer();
    check("R9 new low nibble", 4'h3, 4'hC);

    start_line(1'b1);
    wr_en = 1'b1; wr_row = 9'd240; wr_byte = 7'd0; wr_data = 8'h96;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    do_xfer();
    ov240 = 8'h96;
    check("R9 lower after gap", 4'hC, 4'h9);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule